// File: doc/BRIEF.md
# Conditional Branch Resolver

This block decides, once per cycle, whether a branch is taken and where it goes, for a machine with 32-bit words and instructions. The decoder hands it the branch kind, a five-bit option field, a five-bit condition-bit selector, a long displacement for jumps and a short displacement for conditional branches. The block combines these with the condition register and the current PC. The taken flag, the target and the next PC all follow combinationally from the inputs and the block's own loop-count register.

Four kinds are handled. There are unconditional jumps, relative to the PC or absolute, and conditional branches, also relative to the PC or absolute. A conditional branch can be asked to decrement the loop-count register and test it. It can also be asked to test one bit of the condition register. Each test is enabled by its own bit of the option field. The decrement is committed at the clock edge that closes the cycle in which the branch was presented. A load port lets the pipeline write the count register directly.

Top module: `branch_resolver`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the count register to 0.
- R2: When `cnt_load_en` is high at a rising edge, the count register takes `cnt_load_val`. This takes priority over any decrement requested in the same cycle.
- R3: For a valid conditional branch with option bit 2 (value 4) set, the count test passes and the count register keeps its value.
- R4: For a valid conditional branch with option bit 2 clear, the count register is decremented by one, wrapping from 0 to 0xFFFFFFFF. The count test passes when the decremented value is nonzero and option bit 1 (value 2) is clear, or when it is zero and option bit 1 is set.
- R5: With option bit 4 (value 16) set, the condition test passes. With it clear, the test passes only when `cond_reg[31 - cond_sel]` equals option bit 3 (value 8).
- R6: A valid conditional branch is taken exactly when both tests pass. A valid unconditional jump is always taken and never changes the count register.
- R7: For jumps, the 24-bit `disp_long` is shifted left by 2 and sign-extended from bit 25 of the shifted value.
- R8: For conditional branches, the 14-bit `disp_short` is shifted left by 2 and sign-extended from bit 15 of the shifted value.
- R9: `br_kind` bit 0 selects absolute addressing (1) or PC-relative addressing (0). Relative targets are `pc` plus the extended displacement, modulo 2^32. Absolute targets are the extended value itself. `br_kind` bit 1 selects conditional (1) or unconditional (0).
- R10: `next_pc` equals `target` when `taken` is 1, and `pc + 4` otherwise. While `br_valid` is low, `taken` is 0 and the count register does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_load_en | input | 1 | Write strobe for the count register |
| cnt_load_val | input | 32 | Value written on a load |
| br_valid | input | 1 | A branch is presented this cycle |
| br_kind | input | 2 | Bit 1 = conditional, bit 0 = absolute |
| br_opt | input | 5 | Option field controlling the count and condition tests |
| cond_sel | input | 5 | Selects condition-register bit 31 - cond_sel |
| disp_long | input | 24 | Word displacement for jumps |
| disp_short | input | 14 | Word displacement for conditional branches |
| cond_reg | input | 32 | Condition register |
| pc | input | 32 | Address of the branch |
| taken | output | 1 | Branch outcome |
| target | output | 32 | Branch target address |
| next_pc | output | 32 | Address to fetch next |
| cnt_value | output | 32 | Current count register |

## Verification
The only state in this block is the count register. A wrong decrement or a missed hold shows up on `cnt_value` at the first falling edge after the branch. It also changes the decision of the next branch that tests the count, so one bad cycle can flip a later `taken`. The bench loads counts of 1, 2 and 0 before every one of the 32 option encodings. This puts the test on either side of zero, and it checks the count port after every edge, so a corrupted count is seen within one cycle of the branch that caused it.

// File: rtl/br_pkg.sv
package br_pkg;

   // Branch kind: bit 1 = conditional, bit 0 = absolute addressing
   typedef enum logic [1:0] {
      BK_JUMP_REL = 2'b00,
      BK_JUMP_ABS = 2'b01,
      BK_COND_REL = 2'b10,
      BK_COND_ABS = 2'b11
   } br_kind_e;

   // Option field bit positions (decoded by the test stages)
   localparam int OPT_SKIP_COND = 4;
   localparam int OPT_WANT_SET  = 3;
   localparam int OPT_SKIP_CNT  = 2;
   localparam int OPT_WANT_ZERO = 1;

endpackage

// File: rtl/br_count_test.sv
module br_count_test #(
   parameter int W = 32
) (
   input  logic [W-1:0] cnt_q,
   input  logic         is_cond,
   input  logic         skip_cnt,
   input  logic         want_zero,
   output logic         cnt_ok,
   output logic         dec_req,
   output logic [W-1:0] cnt_dec
);
   logic hit_zero;

   assign cnt_dec  = cnt_q - W'(1);
   assign hit_zero = (cnt_dec == '0);
   assign dec_req  = is_cond & ~skip_cnt;

   always_comb begin
      if (skip_cnt) cnt_ok = 1'b1;
      else          cnt_ok = (hit_zero == want_zero);
   end
endmodule

// File: rtl/br_cond_test.sv
module br_cond_test #(
   parameter int W = 32,
   localparam int SEL_W = $clog2(W)
) (
   input  logic [W-1:0]     cond_reg,
   input  logic [SEL_W-1:0] cond_sel,
   input  logic             skip_cond,
   input  logic             want_set,
   output logic             cond_ok
);
   logic [SEL_W-1:0] bit_idx;
   logic             picked;

   assign bit_idx = SEL_W'(W - 1) - cond_sel;
   assign picked  = cond_reg[bit_idx];
   assign cond_ok = skip_cond | (picked == want_set);
endmodule

// File: rtl/br_target_gen.sv
module br_target_gen #(
   parameter int W        = 32,
   parameter int LONG_W   = 24,
   parameter int SHORT_W  = 14,
   parameter int SHIFT    = 2,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic               is_cond,
   input  logic               is_abs,
   input  logic [LONG_W-1:0]  disp_long,
   input  logic [SHORT_W-1:0] disp_short,
   input  logic [W-1:0]       pc,
   output logic [W-1:0]       target
);
   localparam int LONG_EXT  = W - LONG_W - SHIFT;
   localparam int SHORT_EXT = W - SHORT_W - SHIFT;

   logic [W-1:0] ext_long;
   logic [W-1:0] ext_short;

   assign ext_long  = {{LONG_EXT{disp_long[LONG_W-1]}},   disp_long,  {SHIFT{1'b0}}};
   assign ext_short = {{SHORT_EXT{disp_short[SHORT_W-1]}}, disp_short, {SHIFT{1'b0}}};

   generate
      if (SHARED_ADDER) begin : g_shared
         // One adder behind a displacement mux
         logic [W-1:0] ext_sel;
         logic [W-1:0] base;
         assign ext_sel = is_cond ? ext_short : ext_long;
         assign base    = is_abs ? '0 : pc;
         assign target  = base + ext_sel;
      end else begin : g_split
         // Two adders in parallel, mux after the sums
         logic [W-1:0] sum_long;
         logic [W-1:0] sum_short;
         logic [W-1:0] rel_t;
         logic [W-1:0] abs_t;
         assign sum_long  = pc + ext_long;
         assign sum_short = pc + ext_short;
         assign rel_t     = is_cond ? sum_short : sum_long;
         assign abs_t     = is_cond ? ext_short : ext_long;
         assign target    = is_abs ? abs_t : rel_t;
      end
   endgenerate
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver #(
   parameter int W          = 32,
   parameter int OPT_W      = 5,
   parameter int LONG_W     = 24,
   parameter int SHORT_W    = 14,
   parameter int SHIFT      = 2,
   parameter int INSN_BYTES = 4,
   parameter bit SHARED_ADDER = 1'b1,
   localparam int SEL_W     = $clog2(W)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               cnt_load_en,
   input  logic [W-1:0]       cnt_load_val,
   input  logic               br_valid,
   input  logic [1:0]         br_kind,
   input  logic [OPT_W-1:0]   br_opt,
   input  logic [SEL_W-1:0]   cond_sel,
   input  logic [LONG_W-1:0]  disp_long,
   input  logic [SHORT_W-1:0] disp_short,
   input  logic [W-1:0]       cond_reg,
   input  logic [W-1:0]       pc,
   output logic               taken,
   output logic [W-1:0]       target,
   output logic [W-1:0]       next_pc,
   output logic [W-1:0]       cnt_value
);
   import br_pkg::*;

   generate
      if (OPT_W <= OPT_SKIP_COND) begin : g_bad_opt
         $error("option field too narrow");
      end
      if (LONG_W + SHIFT > W || SHORT_W + SHIFT > W) begin : g_bad_disp
         $error("displacement does not fit the word");
      end
      if ((1 << SEL_W) != W) begin : g_bad_w
         $error("word width must be a power of two");
      end
   endgenerate

   logic         is_cond, is_abs;
   logic         cnt_ok, cond_ok, dec_req;
   logic [W-1:0] cnt_q, cnt_dec, cnt_d;
   logic [OPT_W-1:0] unused_opt;

   assign is_cond    = br_kind[1];
   assign is_abs     = br_kind[0];
   assign unused_opt = br_opt;

   br_count_test #(.W(W)) u_cnt (
      .cnt_q     (cnt_q),
      .is_cond   (is_cond),
      .skip_cnt  (br_opt[OPT_SKIP_CNT]),
      .want_zero (br_opt[OPT_WANT_ZERO]),
      .cnt_ok    (cnt_ok),
      .dec_req   (dec_req),
      .cnt_dec   (cnt_dec)
   );

   br_cond_test #(.W(W)) u_cond (
      .cond_reg  (cond_reg),
      .cond_sel  (cond_sel),
      .skip_cond (br_opt[OPT_SKIP_COND]),
      .want_set  (br_opt[OPT_WANT_SET]),
      .cond_ok   (cond_ok)
   );

   br_target_gen #(
      .W(W), .LONG_W(LONG_W), .SHORT_W(SHORT_W), .SHIFT(SHIFT),
      .SHARED_ADDER(SHARED_ADDER)
   ) u_tgt (
      .is_cond    (is_cond),
      .is_abs     (is_abs),
      .disp_long  (disp_long),
      .disp_short (disp_short),
      .pc         (pc),
      .target     (target)
   );

   assign taken   = br_valid & (~is_cond | (cnt_ok & cond_ok));
   assign next_pc = taken ? target : pc + W'(INSN_BYTES);

   always_comb begin
      if (cnt_load_en)             cnt_d = cnt_load_val;
      else if (br_valid & dec_req) cnt_d = cnt_dec;
      else                         cnt_d = cnt_q;
   end

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_d;
   end

   assign cnt_value = cnt_q;

   p_load_wins_r2: assert property (@(posedge clk) disable iff (rst)
      cnt_load_en |=> cnt_value == $past(cnt_load_val));

   p_cnt_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (br_valid && is_cond && br_opt[OPT_SKIP_CNT] && !cnt_load_en) |=> $stable(cnt_value));

   p_cnt_dec_r4: assert property (@(posedge clk) disable iff (rst)
      (br_valid && is_cond && !br_opt[OPT_SKIP_CNT] && !cnt_load_en)
      |=> cnt_value == $past(cnt_value) - W'(1));

   p_jump_taken_r6: assert property (@(posedge clk) disable iff (rst)
      (br_valid && !is_cond) |-> taken);

   p_jump_keeps_cnt_r6: assert property (@(posedge clk) disable iff (rst)
      (br_valid && !is_cond && !cnt_load_en) |=> $stable(cnt_value));

   p_idle_r10: assert property (@(posedge clk) disable iff (rst)
      !br_valid |-> !taken);

   p_idle_cnt_r10: assert property (@(posedge clk) disable iff (rst)
      (!br_valid && !cnt_load_en) |=> $stable(cnt_value));
endmodule

// File: tb/branch_resolver_test.sv
`timescale 1ns/1ps
module branch_resolver_test;
   logic        clk = 1'b0;
   logic        rst;
   logic        cnt_load_en;
   logic [31:0] cnt_load_val;
   logic        br_valid;
   logic [1:0]  br_kind;
   logic [4:0]  br_opt;
   logic [4:0]  cond_sel;
   logic [23:0] disp_long;
   logic [13:0] disp_short;
   logic [31:0] cond_reg;
   logic [31:0] pc;
   logic        taken;
   logic [31:0] target, next_pc, cnt_value;

   int checks = 0;
   int errors = 0;
   logic [31:0] exp_cnt;
   bit done = 0;

   always #2.5 clk = ~clk;

   branch_resolver uut (
      .clk(clk), .rst(rst), .cnt_load_en(cnt_load_en), .cnt_load_val(cnt_load_val),
      .br_valid(br_valid), .br_kind(br_kind), .br_opt(br_opt), .cond_sel(cond_sel),
      .disp_long(disp_long), .disp_short(disp_short), .cond_reg(cond_reg), .pc(pc),
      .taken(taken), .target(target), .next_pc(next_pc), .cnt_value(cnt_value)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      rst = 0; cnt_load_en = 0; cnt_load_val = 0; br_valid = 0; br_kind = 0;
      br_opt = 0; cond_sel = 0; disp_long = 0; disp_short = 0; cond_reg = 0; pc = 0;
   endtask

   // Advance one clock: from a falling edge to the next falling edge
   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic load_cnt(input logic [31:0] v);
      idle_inputs();
      cnt_load_en = 1; cnt_load_val = v;
      tick();
      exp_cnt = v;
      check("R2 load", cnt_value, exp_cnt);
      cnt_load_en = 0;
   endtask

   // Behavioural reference for one branch, then apply and compare
   task automatic do_branch(input string tag, input logic [1:0] k, input logic [4:0] o,
                            input logic [4:0] s, input logic [23:0] li, input logic [13:0] bd,
                            input logic [31:0] cr, input logic [31:0] p);
      bit          ctr_pass, cr_pass, tk;
      logic [31:0] after, ext, tgt, npc;
      br_valid = 1; br_kind = k; br_opt = o; cond_sel = s;
      disp_long = li; disp_short = bd; cond_reg = cr; pc = p;
      after = exp_cnt;
      if (k[1] == 0) begin
         ext = {6'b0, li, 2'b00};
         if (ext[25]) ext = ext | 32'hFC00_0000;
         tk = 1;
      end else begin
         ext = {16'b0, bd, 2'b00};
         if (ext[15]) ext = ext | 32'hFFFF_0000;
         if (o[2]) ctr_pass = 1;
         else begin
            after = exp_cnt - 1;
            if (after != 0) ctr_pass = (o[1] == 0);
            else            ctr_pass = (o[1] == 1);
         end
         if (o[4]) cr_pass = 1;
         else      cr_pass = (cr[31 - s] == o[3]);
         tk = ctr_pass && cr_pass;
      end
      tgt = k[0] ? ext : p + ext;
      npc = tk ? tgt : p + 32'd4;
      #1;
      check({tag, " taken"}, {31'b0, taken}, {31'b0, tk});
      check({tag, " target"}, target, tgt);
      check({tag, " next_pc"}, next_pc, npc);
      tick();
      exp_cnt = after;
      check({tag, " count"}, cnt_value, exp_cnt);
      br_valid = 0;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      idle_inputs();
      rst = 1;
      @(negedge clk); tick(); tick();
      exp_cnt = 0;
      check("R1 reset", cnt_value, 32'h0);
      rst = 0;

      // R1: reset after a nonzero load
      load_cnt(32'h0000_1234);
      rst = 1; tick(); rst = 0;
      exp_cnt = 0;
      check("R1 reset clears", cnt_value, 32'h0);

      // R3 R4 R5 R6 R8 R9: every option encoding against counts 1, 2, 0
      for (int o = 0; o < 32; o++) begin
         for (int ci = 0; ci < 3; ci++) begin
            logic [31:0] cv, cr;
            cv = (ci == 0) ? 32'd1 : (ci == 1) ? 32'd2 : 32'd0;
            cr = 32'hA5C3_0F96 ^ (32'h1 << ((o * 3 + ci) % 32));
            load_cnt(cv);
            do_branch("R3/R4/R5/R6 sweep", (o % 2) ? 2'b11 : 2'b10, 5'(o),
                      5'((o * 7 + ci * 5) % 32), 24'h12_3456,
                      (ci == 2) ? 14'h2001 : 14'h0040, cr, 32'h0000_8000 + 32'(o * 64));
         end
      end

      // R5: selected bit at both extremes of the selector
      load_cnt(32'd5);
      do_branch("R5 sel0", 2'b10, 5'b00100, 5'd0, 24'h0, 14'h0010, 32'h8000_0000, 32'h100);
      do_branch("R5 sel31", 2'b10, 5'b01100, 5'd31, 24'h0, 14'h0010, 32'h0000_0000, 32'h100);

      // R6 R7 R9: jumps, negative and positive, relative and absolute
      load_cnt(32'd7);
      do_branch("R6/R7 jump rel neg", 2'b00, 5'b00000, 5'd3, 24'h80_0000, 14'h0, 32'h0, 32'h0000_1000);
      do_branch("R6/R7 jump abs pos", 2'b01, 5'b00000, 5'd3, 24'h3F_FFFF, 14'h0, 32'h0, 32'h0000_1000);
      do_branch("R7 jump abs neg", 2'b01, 5'b10100, 5'd3, 24'hFF_FFFF, 14'h0, 32'h0, 32'h0000_1000);
      check("R6 jump keeps count", cnt_value, 32'd7);

      // R8 R9: short displacement sign extension and address wrap
      do_branch("R8 cond abs neg", 2'b11, 5'b10100, 5'd0, 24'h0, 14'h2000, 32'h0, 32'h0000_0040);
      do_branch("R9 wrap", 2'b10, 5'b10100, 5'd0, 24'h0, 14'h0008, 32'h0, 32'hFFFF_FFF0);
      do_branch("R9 wrap back", 2'b00, 5'b00000, 5'd0, 24'hFF_FFF0, 14'h0, 32'h0, 32'h0000_0010);

      // R10: idle cycle leaves count and takes nothing
      idle_inputs();
      br_opt = 5'b00000; br_kind = 2'b10; pc = 32'h0000_2000;
      #1;
      check("R10 idle taken", {31'b0, taken}, 32'h0);
      check("R10 idle next_pc", next_pc, 32'h0000_2004);
      tick();
      check("R10 idle count", cnt_value, exp_cnt);

      // R2: load wins over a decrement in the same cycle
      idle_inputs();
      br_valid = 1; br_kind = 2'b10; br_opt = 5'b10000;
      cnt_load_en = 1; cnt_load_val = 32'h0000_0055;
      tick();
      exp_cnt = 32'h55;
      check("R2 load priority", cnt_value, 32'h0000_0055);

      // R4: decrement wrap from zero
      load_cnt(32'd0);
      do_branch("R4 wrap", 2'b10, 5'b10000, 5'd0, 24'h0, 14'h4, 32'h0, 32'h0);
      check("R4 wrap value", cnt_value, 32'hFFFF_FFFF);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule